// File: doc/BRIEF.md
# Vector Gather/Scatter Line Sequencer

This block moves four 32-bit vector elements between a 128-bit vector register and a cache-line memory port. A command supplies a 64-bit base address, four unsigned 32-bit offsets, a direction flag and, for stores, the four element values. Each element address is the base plus that element's offset. The block groups elements that land in the same 64-byte line and makes one line access per cycle. A gather (load) extracts the elements it needs from the returned line. A scatter (store) places its elements into a line-wide write with a per-word write mask.

The memory port carries one request per cycle under a valid/ready handshake. Read data for a gather access is expected on `mem_rdata` in the same cycle that the request is accepted. A command whose four elements share one line finishes in a single access. The next command can be accepted in that same cycle, so the block sustains one command per cycle. Four distinct lines cost four accesses.

Top module: `vgs_line_seq`

## Requirements
- R1: Element i's address is `cmd_base` plus offset i (bits [32i+31:32i] of `cmd_offs`), zero-extended to 64 bits with full carry. Its line address is address bits [63:6] and its word index is address bits [5:2].
- R2: When all four elements share one line, the command makes exactly one memory access, issued in the cycle after acceptance.
- R3: Each access targets the line of the lowest-numbered element still pending. Every pending element in that line is served by that access. A command makes exactly as many accesses as it has distinct lines (at most four).
- R4: For a gather, `mem_req_write` is 0 and `mem_req_wmask` is all zero. Element i is taken from word (address bits [5:2]) of the returned line. When `done` is high, it appears on `rdata` bits [32i+31:32i].
- R5: For a scatter, `mem_req_write` is 1. Bit w of `mem_req_wmask` is set exactly for the words written by the access, and word w of `mem_req_wdata` (bits [32w+31:32w]) carries the element value. If two served elements share a word, the higher-numbered element's value is written.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, the request is held unchanged into the next cycle and no element is retired.
- R7: `cmd_ready` is high when no command is in progress, or when the final access of the current command completes in that cycle. A command presented while `cmd_ready` is low is ignored.
- R8: `done` is high for exactly the cycle in which the final access of a command is accepted, and at no other time.
- R9: After reset, `mem_req_valid` and `done` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_store | input | 1 | 1 = scatter (store), 0 = gather (load) |
| cmd_base | input | 64 | Base byte address |
| cmd_offs | input | 128 | Four unsigned byte offsets, element i at bits [32i+31:32i] |
| cmd_wdata | input | 128 | Element values for a scatter, element i at bits [32i+31:32i] |
| mem_req_valid | output | 1 | Line access requested |
| mem_req_ready | input | 1 | Memory accepts the access this cycle |
| mem_req_write | output | 1 | Access is a line write |
| mem_req_line_addr | output | 58 | Line address (byte address bits [63:6]) |
| mem_req_wdata | output | 512 | Line write data, word w at bits [32w+31:32w] |
| mem_req_wmask | output | 16 | Per-word write mask |
| mem_rdata | input | 512 | Line read data, valid in the accepting cycle |
| done | output | 1 | Command completes this cycle |
| rdata | output | 128 | Gathered vector, valid while done is high |

## Verification
The hardest situation to reach from the ports combines three events: a multi-line command stalled by the memory, an unwanted command pushed at the block while it is busy, and a final access that overlaps acceptance of the next command. The stimulus chooses offsets that put element 0 in a higher line than later elements, so the issue order cannot be confused with address order. It holds `mem_req_ready` low for one cycle before every access and keeps a junk command on the command port during every non-final access. It also presents two single-line commands so that the second is taken in the same cycle the first signals `done`. A behavioural model computes each expected access and compares it on every access cycle.

// File: rtl/vgs_pkg.sv
// Shared types for the vector gather/scatter line sequencer.
package vgs_pkg;
    // Direction of a command.
    typedef enum logic {
        VGS_GATHER  = 1'b0,
        VGS_SCATTER = 1'b1
    } vgs_op_e;
endpackage

// File: rtl/vgs_addr_gen.sv
// Computes each element's byte address as base + zero-extended offset.
// Splits the address into a line address and a word index within the line.
// Assumes elements are naturally aligned, so byte bits below the word index are dropped.
module vgs_addr_gen #(
    parameter int ADDR_W     = 64,
    parameter int OFF_W      = 32,
    parameter int NUM_ELEM   = 4,
    parameter int LINE_OFF_W = 6,
    parameter int WIDX_W     = 4
) (
    input  logic [ADDR_W-1:0]                           base,
    input  logic [NUM_ELEM*OFF_W-1:0]                   offs,
    output logic [NUM_ELEM*(ADDR_W-LINE_OFF_W)-1:0]     line_addrs,
    output logic [NUM_ELEM*WIDX_W-1:0]                  word_idxs
);
    localparam int LAW  = ADDR_W - LINE_OFF_W;
    localparam int LOWW = LINE_OFF_W - WIDX_W;

    logic [NUM_ELEM*LOWW-1:0] byte_bits_unused;

    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_elem
        logic [ADDR_W-1:0] sum;
        // Full-width add of base and zero-extended offset.
        assign sum = base + {{(ADDR_W-OFF_W){1'b0}}, offs[i*OFF_W +: OFF_W]};
        assign line_addrs[i*LAW +: LAW]      = sum[ADDR_W-1:LINE_OFF_W];
        assign word_idxs[i*WIDX_W +: WIDX_W] = sum[LINE_OFF_W-1:LOWW];
        assign byte_bits_unused[i*LOWW +: LOWW] = sum[LOWW-1:0];
    end
endmodule

// File: rtl/vgs_line_select.sv
// Picks the line of the lowest-numbered pending element and marks every
// pending element in the same line as served this access.
// Assumes at least one pending bit when the result is used.
module vgs_line_select #(
    parameter int NUM_ELEM    = 4,
    parameter int LINE_ADDR_W = 58
) (
    input  logic [NUM_ELEM-1:0]             pending,
    input  logic [NUM_ELEM*LINE_ADDR_W-1:0] line_addrs,
    output logic [LINE_ADDR_W-1:0]          sel_line,
    output logic [NUM_ELEM-1:0]             serve
);
    // Priority pick: first pending element in index order.
    always_comb begin
        logic found;
        found    = 1'b0;
        sel_line = '0;
        for (int i = 0; i < NUM_ELEM; i++) begin
            if (!found && pending[i]) begin
                found    = 1'b1;
                sel_line = line_addrs[i*LINE_ADDR_W +: LINE_ADDR_W];
            end
        end
    end

    // Match every pending element against the chosen line.
    always_comb begin
        for (int i = 0; i < NUM_ELEM; i++) begin
            serve[i] = pending[i] && (line_addrs[i*LINE_ADDR_W +: LINE_ADDR_W] == sel_line);
        end
    end
endmodule

// File: rtl/vgs_lane_xfer.sv
// Moves elements between a cache line and vector lanes.
// Extraction: each lane reads the word selected by its index from the line.
// Insertion: served elements are written into their words in ascending element
// order, so a higher-numbered element overrides a lower one on the same word.
module vgs_lane_xfer #(
    parameter int NUM_ELEM = 4,
    parameter int ELEM_W   = 32,
    parameter int WORDS    = 16,
    parameter int WIDX_W   = 4
) (
    input  logic [NUM_ELEM-1:0]        serve,
    input  logic [NUM_ELEM*WIDX_W-1:0] word_idxs,
    input  logic [WORDS*ELEM_W-1:0]    line_rdata,
    input  logic [NUM_ELEM*ELEM_W-1:0] elem_wdata,
    output logic [NUM_ELEM*ELEM_W-1:0] lane_rdata,
    output logic [WORDS*ELEM_W-1:0]    line_wdata,
    output logic [WORDS-1:0]           word_mask
);
    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_extract
        logic [WIDX_W-1:0] idx;
        assign idx = word_idxs[i*WIDX_W +: WIDX_W];
        // Select this lane's word from the returned line.
        assign lane_rdata[i*ELEM_W +: ELEM_W] = line_rdata[idx*ELEM_W +: ELEM_W];
    end

    // Build the line write image and word mask, later elements winning.
    always_comb begin
        line_wdata = '0;
        word_mask  = '0;
        for (int e = 0; e < NUM_ELEM; e++) begin
            for (int w = 0; w < WORDS; w++) begin
                if (serve[e] && (word_idxs[e*WIDX_W +: WIDX_W] == WIDX_W'(w))) begin
                    line_wdata[w*ELEM_W +: ELEM_W] = elem_wdata[e*ELEM_W +: ELEM_W];
                    word_mask[w]                   = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vgs_line_seq.sv
// Top of the gather/scatter line sequencer.
// Accepts one command, then issues one line access per cycle until every
// element has been served. done and the gathered vector are combinational
// with the final accepted access, and a new command may be taken that cycle.
// Assumes mem_rdata is valid in the cycle a read access is accepted.
module vgs_line_seq
    import vgs_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int OFF_W      = 32,
    parameter int ELEM_W     = 32,
    parameter int NUM_ELEM   = 4,
    parameter int LINE_BYTES = 64
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cmd_valid,
    output logic                                  cmd_ready,
    input  logic                                  cmd_store,
    input  logic [ADDR_W-1:0]                     cmd_base,
    input  logic [NUM_ELEM*OFF_W-1:0]             cmd_offs,
    input  logic [NUM_ELEM*ELEM_W-1:0]            cmd_wdata,
    output logic                                  mem_req_valid,
    input  logic                                  mem_req_ready,
    output logic                                  mem_req_write,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  mem_req_line_addr,
    output logic [LINE_BYTES*8-1:0]               mem_req_wdata,
    output logic [LINE_BYTES/(ELEM_W/8)-1:0]      mem_req_wmask,
    input  logic [LINE_BYTES*8-1:0]               mem_rdata,
    output logic                                  done,
    output logic [NUM_ELEM*ELEM_W-1:0]            rdata
);
    localparam int LINE_OFF_W  = $clog2(LINE_BYTES);
    localparam int WORDS       = LINE_BYTES / (ELEM_W / 8);
    localparam int WIDX_W      = $clog2(WORDS);
    localparam int LINE_ADDR_W = ADDR_W - LINE_OFF_W;
    localparam int VEC_W       = NUM_ELEM * ELEM_W;

    logic [NUM_ELEM-1:0]             pend_q;
    vgs_op_e                         op_q;
    logic [NUM_ELEM*LINE_ADDR_W-1:0] line_q;
    logic [NUM_ELEM*WIDX_W-1:0]      widx_q;
    logic [VEC_W-1:0]                wdata_q;
    logic [VEC_W-1:0]                res_q;

    logic [NUM_ELEM*LINE_ADDR_W-1:0] line_d;
    logic [NUM_ELEM*WIDX_W-1:0]      widx_d;
    logic [LINE_ADDR_W-1:0]          sel_line;
    logic [NUM_ELEM-1:0]             serve;
    logic [NUM_ELEM-1:0]             pend_nxt;
    logic [VEC_W-1:0]                lane_rd;
    logic [WORDS*ELEM_W-1:0]         ins_line;
    logic [WORDS-1:0]                ins_mask;
    logic                            accept;
    logic                            fire;

    vgs_addr_gen #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_ELEM(NUM_ELEM),
        .LINE_OFF_W(LINE_OFF_W), .WIDX_W(WIDX_W)
    ) addr_i (
        .base(cmd_base), .offs(cmd_offs),
        .line_addrs(line_d), .word_idxs(widx_d)
    );

    vgs_line_select #(
        .NUM_ELEM(NUM_ELEM), .LINE_ADDR_W(LINE_ADDR_W)
    ) sel_i (
        .pending(pend_q), .line_addrs(line_q),
        .sel_line(sel_line), .serve(serve)
    );

    vgs_lane_xfer #(
        .NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .WORDS(WORDS), .WIDX_W(WIDX_W)
    ) xfer_i (
        .serve(serve), .word_idxs(widx_q), .line_rdata(mem_rdata),
        .elem_wdata(wdata_q), .lane_rdata(lane_rd),
        .line_wdata(ins_line), .word_mask(ins_mask)
    );

    // Handshake and completion decode.
    always_comb begin
        mem_req_valid = |pend_q;
        fire          = mem_req_valid && mem_req_ready;
        pend_nxt      = pend_q & ~serve;
        done          = fire && (pend_nxt == '0);
        cmd_ready     = (pend_q == '0) || done;
        accept        = cmd_valid && cmd_ready;
    end

    // Drive the memory request fields.
    always_comb begin
        mem_req_line_addr = sel_line;
        mem_req_write     = mem_req_valid && (op_q == VGS_SCATTER);
        mem_req_wdata     = ins_line;
        mem_req_wmask     = mem_req_write ? ins_mask : '0;
    end

    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_result
        // Forward lanes served by the final access, else the captured lane.
        assign rdata[i*ELEM_W +: ELEM_W] =
            (fire && (op_q == VGS_GATHER) && serve[i]) ? lane_rd[i*ELEM_W +: ELEM_W]
                                                       : res_q[i*ELEM_W +: ELEM_W];
    end

    // Command capture and per-access retirement of served elements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            op_q    <= VGS_GATHER;
            line_q  <= '0;
            widx_q  <= '0;
            wdata_q <= '0;
            res_q   <= '0;
        end else if (accept) begin
            pend_q  <= '1;
            op_q    <= cmd_store ? VGS_SCATTER : VGS_GATHER;
            line_q  <= line_d;
            widx_q  <= widx_d;
            wdata_q <= cmd_wdata;
            res_q   <= '0;
        end else if (fire) begin
            pend_q <= pend_nxt;
            for (int i = 0; i < NUM_ELEM; i++) begin
                if (serve[i] && (op_q == VGS_GATHER)) begin
                    res_q[i*ELEM_W +: ELEM_W] <= lane_rd[i*ELEM_W +: ELEM_W];
                end
            end
        end
    end
endmodule

// File: rtl/vgs_line_seq_chk.sv
// Protocol checker for the line sequencer, attached by bind below.
// Watches only the ports and counts accesses per command.
module vgs_line_seq_chk #(
    parameter int LINE_ADDR_W = 58,
    parameter int NUM_ELEM    = 4,
    parameter int WORDS       = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic                   cmd_ready,
    input logic                   mem_req_valid,
    input logic                   mem_req_ready,
    input logic                   mem_req_write,
    input logic [LINE_ADDR_W-1:0] mem_req_line_addr,
    input logic [WORDS-1:0]       mem_req_wmask,
    input logic                   done
);
    localparam int CNT_W = $clog2(NUM_ELEM + 1) + 1;

    logic             accept;
    logic             fire;
    logic [CNT_W-1:0] acc_cnt;

    assign accept = cmd_valid && cmd_ready;
    assign fire   = mem_req_valid && mem_req_ready;

    // Count accepted accesses since the last command acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_cnt <= '0;
        else if (accept) acc_cnt <= '0;
        else if (fire)   acc_cnt <= acc_cnt + 1'b1;
    end

    p_cap_four_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (acc_cnt < CNT_W'(NUM_ELEM)));

    p_issue_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> mem_req_valid);

    p_gather_no_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> (mem_req_wmask == '0));

    p_scatter_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_wmask != '0));

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_line_addr) && $stable(mem_req_write)
             && $stable(mem_req_wmask)));

    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !done) |-> !cmd_ready);

    p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    p_done_on_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fire);
endmodule

bind vgs_line_seq vgs_line_seq_chk #(
    .LINE_ADDR_W(LINE_ADDR_W), .NUM_ELEM(NUM_ELEM), .WORDS(WORDS)
) chk_i (.*);

// File: tb/vgs_line_seq_tb.sv
// Bench for the line sequencer: a behavioural model derives each expected
// access from the command and compares it on every access cycle.
module vgs_line_seq_tb_top;
    localparam int LAW = 58;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cmd_valid, cmd_ready, cmd_store;
    logic [63:0]  cmd_base;
    logic [127:0] cmd_offs, cmd_wdata;
    logic         mem_req_valid, mem_req_ready, mem_req_write;
    logic [LAW-1:0] mem_req_line_addr;
    logic [511:0] mem_req_wdata, mem_rdata;
    logic [15:0]  mem_req_wmask;
    logic         done;
    logic [127:0] rdata;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    vgs_line_seq dut_i (.*);

    // Line contents are a pure function of line address and word index.
    function automatic logic [31:0] memword(input logic [LAW-1:0] l, input int w);
        return {l[27:0], 4'(w)} ^ 32'hC3A5_0000;
    endfunction

    always_comb begin
        for (int w = 0; w < 16; w++) mem_rdata[w*32 +: 32] = memword(mem_req_line_addr, w);
    end

    task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Run one command through the model; stall adds a ready-low cycle before
    // each access, intrude presents a junk command during non-final accesses.
    task automatic run_cmd(input logic st, input logic [63:0] base, input logic [127:0] offs,
                           input logic [127:0] wd, input bit stall, input bit intrude);
        logic [LAW-1:0] la[4];
        logic [3:0]     wi[4];
        logic [3:0]     pend, srv, nxt;
        logic [127:0]   exp_res;
        logic [LAW-1:0] cur;
        logic [511:0]   ewd;
        logic [15:0]    emsk;
        bit             last;
        int             nacc;
        for (int i = 0; i < 4; i++) begin
            logic [63:0] a;
            a = base + {32'h0, offs[i*32 +: 32]};
            la[i] = a[63:6];
            wi[i] = a[5:2];
        end
        pend = 4'hf; exp_res = '0; nacc = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_store = st; cmd_base = base; cmd_offs = offs; cmd_wdata = wd;
        mem_req_ready = 1'b1;
        #1 chk(cmd_ready == 1'b1, "R7 ready when idle", 512'(cmd_ready), 512'(1));
        @(posedge clk);
        while (pend != 0) begin
            cur = '0;
            for (int i = 3; i >= 0; i--) if (pend[i]) cur = la[i];
            srv = '0; ewd = '0; emsk = '0;
            for (int i = 0; i < 4; i++) if (pend[i] && la[i] == cur) begin
                srv[i] = 1'b1;
                ewd[wi[i]*32 +: 32] = wd[i*32 +: 32];
                emsk[wi[i]] = 1'b1;
                exp_res[i*32 +: 32] = memword(la[i], int'(wi[i]));
            end
            nxt = pend & ~srv;
            last = (nxt == 0);
            nacc++;
            @(negedge clk);
            cmd_valid = intrude && !last;
            cmd_base = 64'hDEAD_0000_0000_0000; cmd_offs = '0; cmd_store = ~st;
            if (stall) begin
                mem_req_ready = 1'b0;
                #1;
                chk(mem_req_valid && mem_req_line_addr == cur, "R6 stalled request", 512'(mem_req_line_addr), 512'(cur));
                chk(!done && !cmd_ready, "R8 no done while stalled", 512'({done, cmd_ready}), 512'(0));
                @(negedge clk);
                mem_req_ready = 1'b1;
            end
            #1;
            chk(mem_req_valid == 1'b1, "R3 access valid", 512'(mem_req_valid), 512'(1));
            chk(mem_req_line_addr == cur, "R3 R1 line order", 512'(mem_req_line_addr), 512'(cur));
            chk(mem_req_write == st, "R4 R5 write flag", 512'(mem_req_write), 512'(st));
            chk(done == last, "R8 done on final access", 512'(done), 512'(last));
            chk(cmd_ready == last, "R7 ready only on final access", 512'(cmd_ready), 512'(last));
            if (st) begin
                chk(mem_req_wmask == emsk, "R5 word mask", 512'(mem_req_wmask), 512'(emsk));
                for (int w = 0; w < 16; w++) if (emsk[w])
                    chk(mem_req_wdata[w*32 +: 32] == ewd[w*32 +: 32], "R5 write word",
                        512'(mem_req_wdata[w*32 +: 32]), 512'(ewd[w*32 +: 32]));
            end else begin
                chk(mem_req_wmask == 16'h0, "R4 gather mask zero", 512'(mem_req_wmask), 512'(0));
                if (last) chk(rdata == exp_res, "R4 R1 gathered vector", 512'(rdata), 512'(exp_res));
            end
            pend = nxt;
            @(posedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        #1 chk(!mem_req_valid && !done && cmd_ready, "R3 idle after final access",
               512'({mem_req_valid, done, cmd_ready}), 512'(1));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [127:0] ea, eb;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_store = 1'b0; cmd_base = '0;
        cmd_offs = '0; cmd_wdata = '0; mem_req_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk(!mem_req_valid && !done && cmd_ready, "R9 reset state",
               512'({mem_req_valid, done, cmd_ready}), 512'(1));

        // R2: all four in one line.
        run_cmd(1'b0, 64'h1000, {32'h20, 32'h3C, 32'h0, 32'h8}, '0, 1'b0, 1'b0);
        // R3: four lines, element 0 in the highest line.
        run_cmd(1'b0, 64'h2000, {32'h04, 32'h40, 32'h80, 32'hC0}, '0, 1'b0, 1'b0);
        // R3: elements 0,2 share a line, 1,3 share another.
        run_cmd(1'b0, 64'h3000, {32'h14, 32'h13C, 32'h10, 32'h104}, '0, 1'b0, 1'b0);
        // R5: one-line scatter, elements 1 and 3 hit the same word.
        run_cmd(1'b1, 64'h4000, {32'h24, 32'h8, 32'h24, 32'h0},
                {32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h0000_0000}, 1'b0, 1'b0);
        // R6 R7: three-line scatter with stalls and a junk command.
        run_cmd(1'b1, 64'h5000, {32'h1C0, 32'h88, 32'h0, 32'h80},
                {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000}, 1'b1, 1'b1);
        // R1 R6: gather across a 32-bit carry boundary, with stalls.
        run_cmd(1'b0, 64'h0000_0001_FFFF_FFC0, {32'h100, 32'h48, 32'h3C, 32'h44}, '0, 1'b1, 1'b1);

        // R2 R7: two single-line gathers back to back, one command per cycle.
        ea = {memword(58'h80, 3), memword(58'h80, 2), memword(58'h80, 1), memword(58'h80, 0)};
        eb = {memword(58'h95, 15), memword(58'h95, 15), memword(58'h95, 0), memword(58'h95, 7)};
        @(negedge clk);
        cmd_valid = 1'b1; cmd_store = 1'b0; cmd_base = 64'h2000;
        cmd_offs = {32'hC, 32'h8, 32'h4, 32'h0}; mem_req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_base = 64'h2540; cmd_offs = {32'h3C, 32'h3C, 32'h0, 32'h1C};
        #1;
        chk(mem_req_line_addr == 58'h80 && done, "R2 first single access", 512'(mem_req_line_addr), 512'(58'h80));
        chk(cmd_ready == 1'b1, "R7 ready during final access", 512'(cmd_ready), 512'(1));
        chk(rdata == ea, "R4 first vector", 512'(rdata), 512'(ea));
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk(mem_req_line_addr == 58'h95 && done, "R2 second command next cycle", 512'(mem_req_line_addr), 512'(58'h95));
        chk(rdata == eb, "R4 second vector", 512'(rdata), 512'(eb));
        @(negedge clk);
        #1 chk(!mem_req_valid && !done, "R8 done not repeated", 512'({mem_req_valid, done}), 512'(0));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule